// File: doc/BRIEF.md
# SDRAM Bank Command Legality Checker

This block sits beside the command pins of a two-bank synchronous DRAM and watches them. Each clock edge it turns chip select, row strobe, column strobe and write enable into one command, picks the bank or banks the command reaches, and judges the command against the state that bank is in. A legal command moves the bank through its states: idle, row active, write recovery, write recovery with auto-precharge, precharging, refreshing and mode-register access. An illegal command leaves every bank as it was. It raises a one-cycle flag with a code that gives the reason.

Every timed window is a parameter counted in clocks. These are the activate-to-column delay, the activate-to-precharge minimum, the activate-to-activate spacing, the write-recovery time, the precharge time and the refresh cycle. Each bank runs its own down-counters for them. A device-level clock-enable tracker handles power-down and self refresh and blocks judgement while the clock enable was low. The block is meant for simulation monitors and for silicon debug logic on a memory controller.

Top module: `sdchk_top`

## Requirements
- R1: The command is decoded from (chip_sel_n, row_strobe_n, col_strobe_n, write_en_n). chip_sel_n=1 is deselect. With chip_sel_n=0 the codes are: 111 no-op, 110 burst stop, 101 read, 100 write, 011 activate, 010 precharge, 001 refresh, 000 mode-register set. Deselect and no-op are legal in every bank state and never change a state.
- R2: An illegal command sets `illegal` high for exactly the one cycle after the edge that sampled it, with `viol_code` 1 for a bad state, 2 for the activate-to-column delay, 3 for the activate-to-precharge minimum and 4 for activate spacing. Otherwise `viol_code` is 0. An illegal command changes no bank state.
- R3: Activate on an idle bank makes it row active (state code 1). A read or write to that bank fewer than TRCD edges after the activate gives code 2. At TRCD edges or more it is legal.
- R4: Precharge to a row-active bank fewer than TRAS edges after its activate gives code 3. Otherwise the bank shows precharging (code 4) for TRP cycles and then idle (code 0). ap_bit=1 on a precharge reaches every bank.
- R5: An activate fewer than TRRD edges after the previous accepted activate gives code 4.
- R6: A write to a row-active bank gives write recovery (code 2) for TDPL cycles and then row active. With ap_bit=1 it gives write recovery with auto-precharge (code 3) for TDPL cycles, then precharging for TRP cycles, then idle.
- R7: In write recovery, a read or write is accepted and ap_bit picks auto-precharge. Activate, precharge, refresh and mode-register set give code 1. A command on the last recovery cycle is judged against write recovery, and the timed exit still happens.
- R8: In write recovery with auto-precharge, every command other than deselect, no-op and burst stop gives code 1.
- R9: Refresh with both banks idle makes both banks refreshing (code 5) for TRC cycles and then idle. Only deselect, no-op and burst stop are legal in that state.
- R10: Mode-register set with both banks idle holds both banks in mode access (code 6) for exactly 2 cycles. Any command there except deselect or no-op, including burst stop, gives code 1.
- R11: A read, write, activate or single-bank precharge is judged only against the bank that bank_sel picks. The other bank's state has no effect on the verdict.
- R12: A command is judged only when clk_en was high at the previous edge. A judged deselect or no-op with clk_en low and both banks idle gives power-down (pwr_state 1). A judged refresh with clk_en low gives self refresh (pwr_state 2) and leaves the banks idle. clk_en high leaves either state (pwr_state 0). Commands seen while the clock enable is low are ignored.
- R13: A synchronous reset returns both banks to idle, pwr_state to 0 and clears the flag, the code and all counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| clk_en | input | 1 | Memory clock enable as driven to the device |
| chip_sel_n | input | 1 | Chip select, active low |
| row_strobe_n | input | 1 | Row strobe, active low |
| col_strobe_n | input | 1 | Column strobe, active low |
| write_en_n | input | 1 | Write enable, active low |
| bank_sel | input | BAW | Bank select |
| ap_bit | input | 1 | Auto-precharge / all-bank address bit |
| illegal | output | 1 | One-cycle violation pulse |
| viol_code | output | 4 | Violation reason, 0 when none |
| bank_state | output | 3*NB | State code per bank, bank i at bits [3i+2:3i] |
| pwr_state | output | 2 | 0 running, 1 power-down, 2 self refresh |

## Verification
A bank's timed exit and a freshly sampled command can fall in the same cycle. This happens when a command arrives on the last cycle of write recovery, precharge, refresh or mode access. The bench provokes it by issuing an activate exactly TDPL edges after a write. It judges that the verdict uses the old state (code 1) and that the bank still lands in row active on that edge. A sweep issues every command variant in every reachable bank state and compares the code with a table restated in the bench.

// File: rtl/sdchk_pkg.sv
package sdchk_pkg;

  typedef enum logic [3:0] {
    C_DESL, C_NOP, C_BST, C_READ, C_WRIT, C_ACT, C_PRE, C_REF, C_MRS
  } cmd_e;

  typedef enum logic [2:0] {
    S_IDLE = 3'd0, S_ACTV = 3'd1, S_WREC = 3'd2, S_WRAP = 3'd3,
    S_PRCH = 3'd4, S_RFSH = 3'd5, S_MODE = 3'd6
  } bank_st_e;

  typedef enum logic [1:0] {P_RUN = 2'd0, P_PDN = 2'd1, P_SELF = 2'd2} pwr_e;

  localparam logic [3:0] V_NONE  = 4'd0;
  localparam logic [3:0] V_STATE = 4'd1;
  localparam logic [3:0] V_RCD   = 4'd2;
  localparam logic [3:0] V_RAS   = 4'd3;
  localparam logic [3:0] V_RRD   = 4'd4;

  // Turn the four strobes into a command.
  function automatic cmd_e decode_cmd(input logic cs_n, input logic r_n,
                                      input logic c_n, input logic w_n);
    if (cs_n) return C_DESL;
    case ({r_n, c_n, w_n})
      3'b111:  return C_NOP;
      3'b110:  return C_BST;
      3'b101:  return C_READ;
      3'b100:  return C_WRIT;
      3'b011:  return C_ACT;
      3'b010:  return C_PRE;
      3'b001:  return C_REF;
      default: return C_MRS;
    endcase
  endfunction

  // Counter load for a window of t clocks; the counter reaches zero on the t-th edge.
  function automatic int unsigned ld_of(input int unsigned t);
    return (t == 0) ? 0 : t - 1;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sdchk_decode.sv
module sdchk_decode
  import sdchk_pkg::*;
#(
  parameter int NB  = 2,
  parameter int BAW = 1
) (
  input  logic           chip_sel_n,
  input  logic           row_n,
  input  logic           col_n,
  input  logic           we_n,
  input  logic [BAW-1:0] bank_sel,
  input  logic           ap,
  output cmd_e           cmd,
  output logic [NB-1:0]  hit
);

  always_comb begin
    cmd = decode_cmd(chip_sel_n, row_n, col_n, we_n);
    hit = '0;
    case (cmd)
      C_READ, C_WRIT, C_ACT:
        for (int i = 0; i < NB; i++) hit[i] = (bank_sel == BAW'(i));
      C_PRE:
        for (int i = 0; i < NB; i++) hit[i] = ap || (bank_sel == BAW'(i));
      C_BST, C_REF, C_MRS:
        hit = '1;
      default:
        hit = '0;
    endcase
  end

endmodule

// File: rtl/sdchk_bank.sv
module sdchk_bank
  import sdchk_pkg::*;
#(
  parameter int TDPL = 2,
  parameter int TRC  = 4,
  parameter int TRCD = 2,
  parameter int TRAS = 4,
  parameter int TRP  = 2,
  parameter int CW   = 3
) (
  input  logic      clk,
  input  logic      rst,
  input  cmd_e      cmd,
  input  logic      hit,
  input  logic      ap,
  input  logic      rrd_ok,
  input  logic      commit,
  input  logic      self_req,
  output bank_st_e  st,
  output logic [3:0] code,
  output logic      idle
);

  localparam logic [CW-1:0] L_DPL  = CW'(ld_of(TDPL));
  localparam logic [CW-1:0] L_RC   = CW'(ld_of(TRC));
  localparam logic [CW-1:0] L_RCD  = CW'(ld_of(TRCD));
  localparam logic [CW-1:0] L_RAS  = CW'(ld_of(TRAS));
  localparam logic [CW-1:0] L_RP   = CW'(ld_of(TRP));
  localparam logic [CW-1:0] L_MODE = CW'(ld_of(2));

  bank_st_e        st_q, nxt, tmo;
  logic [CW-1:0]   cnt_q, ld, tmo_ld, rcd_q, ras_q;
  logic            chg, timed, take, expire, rcd_zero, ras_zero;

  assign rcd_zero = (rcd_q == '0);
  assign ras_zero = (ras_q == '0);

  // Legality table for commands that reach this bank.
  always_comb begin
    code = V_NONE;
    nxt  = st_q;
    ld   = '0;
    chg  = 1'b0;
    if (hit) begin
      case (st_q)
        S_IDLE:
          case (cmd)
            C_READ, C_WRIT: code = V_STATE;
            C_ACT:
              if (!rrd_ok) code = V_RRD;
              else begin nxt = S_ACTV; chg = 1'b1; end
            C_REF: begin
              chg = 1'b1;
              if (self_req) nxt = S_IDLE;
              else begin nxt = S_RFSH; ld = L_RC; end
            end
            C_MRS: begin nxt = S_MODE; ld = L_MODE; chg = 1'b1; end
            default: ;
          endcase
        S_ACTV:
          case (cmd)
            C_READ:
              if (!rcd_zero) code = V_RCD;
              else if (ap) begin nxt = S_PRCH; ld = L_RP; chg = 1'b1; end
            C_WRIT:
              if (!rcd_zero) code = V_RCD;
              else begin nxt = ap ? S_WRAP : S_WREC; ld = L_DPL; chg = 1'b1; end
            C_PRE:
              if (!ras_zero) code = V_RAS;
              else begin nxt = S_PRCH; ld = L_RP; chg = 1'b1; end
            C_ACT, C_REF, C_MRS: code = V_STATE;
            default: ;
          endcase
        S_WREC:
          case (cmd)
            C_READ: begin
              chg = 1'b1;
              if (ap) begin nxt = S_PRCH; ld = L_RP; end
              else nxt = S_ACTV;
            end
            C_WRIT: begin nxt = ap ? S_WRAP : S_WREC; ld = L_DPL; chg = 1'b1; end
            C_ACT, C_PRE, C_REF, C_MRS: code = V_STATE;
            default: ;
          endcase
        S_WRAP, S_RFSH:
          if (cmd != C_BST) code = V_STATE;
        S_PRCH:
          case (cmd)
            C_READ, C_WRIT, C_ACT, C_REF, C_MRS: code = V_STATE;
            default: ;
          endcase
        S_MODE:
          code = V_STATE;
        default:
          code = V_STATE;
      endcase
    end
  end

  // Timed exits.
  always_comb begin
    tmo    = st_q;
    tmo_ld = '0;
    timed  = 1'b1;
    case (st_q)
      S_WREC:                 tmo = S_ACTV;
      S_WRAP: begin           tmo = S_PRCH; tmo_ld = L_RP; end
      S_PRCH, S_RFSH, S_MODE: tmo = S_IDLE;
      default:                timed = 1'b0;
    endcase
  end

  assign take   = commit && hit && chg;
  assign expire = !take && timed && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= S_IDLE;
      cnt_q <= '0;
      rcd_q <= '0;
      ras_q <= '0;
    end else begin
      if (take) begin
        st_q  <= nxt;
        cnt_q <= ld;
      end else if (expire) begin
        st_q  <= tmo;
        cnt_q <= tmo_ld;
      end else if (cnt_q != '0) begin
        cnt_q <= cnt_q - 1'b1;
      end
      if (take && cmd == C_ACT) begin
        rcd_q <= L_RCD;
        ras_q <= L_RAS;
      end else begin
        if (!rcd_zero) rcd_q <= rcd_q - 1'b1;
        if (!ras_zero) ras_q <= ras_q - 1'b1;
      end
    end
  end

  assign st   = st_q;
  assign idle = (st_q == S_IDLE);

  // R2: with no accepted command and the timer still running, the state holds.
  assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (!take && cnt_q != '0) |=> st_q == $past(st_q));

  // R10: mode access never lasts beyond two cycles.
  assert_mode_len_R10: assert property (@(posedge clk) disable iff (rst)
    (st_q == S_MODE && $past(st_q) == S_MODE) |=> st_q != S_MODE);

  // R3: an accepted column command from row active saw the delay counter at zero.
  assert_rcd_R3: assert property (@(posedge clk) disable iff (rst)
    (take && st_q == S_ACTV && (cmd == C_READ || cmd == C_WRIT)) |-> rcd_q == '0);

endmodule

// File: rtl/sdchk_power.sv
module sdchk_power
  import sdchk_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic clk_en,
  input  cmd_e cmd,
  input  logic all_idle,
  input  logic cmd_ok,
  output logic judge,
  output logic self_req,
  output pwr_e pwr
);

  logic cke_q;
  pwr_e pwr_q;

  assign judge    = cke_q && (pwr_q == P_RUN);
  assign self_req = judge && !clk_en && (cmd == C_REF);

  always_ff @(posedge clk) begin
    if (rst) begin
      cke_q <= 1'b0;
      pwr_q <= P_RUN;
    end else begin
      cke_q <= clk_en;
      case (pwr_q)
        P_RUN:
          if (judge && !clk_en && cmd_ok) begin
            if (cmd == C_REF) pwr_q <= P_SELF;
            else if (all_idle && (cmd == C_DESL || cmd == C_NOP)) pwr_q <= P_PDN;
          end
        default:
          if (clk_en) pwr_q <= P_RUN;
      endcase
    end
  end

  assign pwr = pwr_q;

  // R12: clock enable high always brings a low-power state back to running.
  assert_wake_R12: assert property (@(posedge clk) disable iff (rst)
    (pwr_q != P_RUN && clk_en) |=> pwr_q == P_RUN);

endmodule

// File: rtl/sdchk_top.sv
module sdchk_top
  import sdchk_pkg::*;
#(
  parameter int NB   = 2,
  parameter int TDPL = 2,
  parameter int TRC  = 4,
  parameter int TRCD = 2,
  parameter int TRAS = 4,
  parameter int TRRD = 2,
  parameter int TRP  = 2,
  localparam int BAW = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clk_en,
  input  logic            chip_sel_n,
  input  logic            row_strobe_n,
  input  logic            col_strobe_n,
  input  logic            write_en_n,
  input  logic [BAW-1:0]  bank_sel,
  input  logic            ap_bit,
  output logic            illegal,
  output logic [3:0]      viol_code,
  output logic [3*NB-1:0] bank_state,
  output logic [1:0]      pwr_state
);

  localparam int MAXT = max2(max2(max2(TDPL, TRC), max2(TRCD, TRAS)),
                             max2(max2(TRRD, TRP), 2));
  localparam int CW   = $clog2(MAXT + 1);
  localparam logic [CW-1:0] L_RRD = CW'(ld_of(TRRD));

  cmd_e          cmd;
  logic [NB-1:0] hit, idle_v;
  logic [3:0]    bcode [NB];
  logic [3:0]    any_code;
  logic          judge, self_req, commit, act_commit, rrd_ok, cmd_ok;
  logic [CW-1:0] rrd_q;
  pwr_e          pwr;
  logic          illegal_q;
  logic [3:0]    code_q;

  sdchk_decode #(.NB(NB), .BAW(BAW)) u_dec (
    .chip_sel_n (chip_sel_n),
    .row_n      (row_strobe_n),
    .col_n      (col_strobe_n),
    .we_n       (write_en_n),
    .bank_sel   (bank_sel),
    .ap         (ap_bit),
    .cmd        (cmd),
    .hit        (hit)
  );

  generate
    for (genvar g = 0; g < NB; g++) begin : g_bank
      bank_st_e st_g;
      sdchk_bank #(
        .TDPL(TDPL), .TRC(TRC), .TRCD(TRCD), .TRAS(TRAS), .TRP(TRP), .CW(CW)
      ) u_bank (
        .clk      (clk),
        .rst      (rst),
        .cmd      (cmd),
        .hit      (hit[g]),
        .ap       (ap_bit),
        .rrd_ok   (rrd_ok),
        .commit   (commit),
        .self_req (self_req),
        .st       (st_g),
        .code     (bcode[g]),
        .idle     (idle_v[g])
      );
      assign bank_state[3*g +: 3] = st_g;
    end
  endgenerate

  // Lowest-numbered bank with a complaint sets the reported reason.
  always_comb begin
    any_code = V_NONE;
    for (int i = NB - 1; i >= 0; i--)
      if (bcode[i] != V_NONE) any_code = bcode[i];
  end

  assign cmd_ok     = (any_code == V_NONE);
  assign commit     = judge && cmd_ok;
  assign act_commit = commit && (cmd == C_ACT);
  assign rrd_ok     = (rrd_q == '0);

  sdchk_power u_pwr (
    .clk      (clk),
    .rst      (rst),
    .clk_en   (clk_en),
    .cmd      (cmd),
    .all_idle (&idle_v),
    .cmd_ok   (cmd_ok),
    .judge    (judge),
    .self_req (self_req),
    .pwr      (pwr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rrd_q     <= '0;
      illegal_q <= 1'b0;
      code_q    <= V_NONE;
    end else begin
      if (act_commit)  rrd_q <= L_RRD;
      else if (!rrd_ok) rrd_q <= rrd_q - 1'b1;
      illegal_q <= judge && !cmd_ok;
      code_q    <= judge ? any_code : V_NONE;
    end
  end

  assign illegal   = illegal_q;
  assign viol_code = code_q;
  assign pwr_state = pwr;

  // R12: an edge that is not judged never produces a violation.
  assert_quiet_R12: assert property (@(posedge clk) disable iff (rst)
    !judge |=> !illegal);

  // R5: with a spacing above one clock, two accepted activates never sit back to back.
  assert_spacing_R5: assert property (@(posedge clk) disable iff (rst)
    (TRRD > 1 && act_commit) |=> !act_commit);

endmodule

// File: tb/sim_sdchk_top.sv
module sim_sdchk_top;

  localparam int TDPL = 2, TRC = 4, TRCD = 2, TRAS = 4, TRRD = 2, TRP = 2;

  logic       clk = 1'b0;
  logic       rst, clk_en, cs_n, r_n, c_n, w_n, ap;
  logic [0:0] bsel;
  logic       illegal;
  logic [3:0] viol_code;
  logic [5:0] bank_state;
  logic [1:0] pwr_state;

  int nchk = 0;
  int nfail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  sdchk_top #(.NB(2), .TDPL(TDPL), .TRC(TRC), .TRCD(TRCD), .TRAS(TRAS),
              .TRRD(TRRD), .TRP(TRP)) u0 (
    .clk(clk), .rst(rst), .clk_en(clk_en), .chip_sel_n(cs_n),
    .row_strobe_n(r_n), .col_strobe_n(c_n), .write_en_n(w_n),
    .bank_sel(bsel), .ap_bit(ap), .illegal(illegal), .viol_code(viol_code),
    .bank_state(bank_state), .pwr_state(pwr_state)
  );

  // Variants: 0 DESL 1 NOP 2 BST 3 READ 4 READ+AP 5 WRIT 6 WRIT+AP
  //           7 ACT 8 PRE 9 PRE-all 10 REF 11 MRS
  task automatic put(input int v, input int b, input logic cke);
    logic [3:0] p;
    case (v)
      0: p = 4'b1111; 1: p = 4'b0111; 2: p = 4'b0110;
      3, 4: p = 4'b0101; 5, 6: p = 4'b0100; 7: p = 4'b0011;
      8, 9: p = 4'b0010; 10: p = 4'b0001; default: p = 4'b0000;
    endcase
    {cs_n, r_n, c_n, w_n} = p;
    ap     = (v == 4 || v == 6 || v == 9);
    bsel   = b[0:0];
    clk_en = cke;
    @(posedge clk);
    #1;
  endtask

  task automatic nop(input int n);
    for (int i = 0; i < n; i++) put(1, 0, 1'b1);
  endtask

  task automatic reset_dut();
    rst = 1'b1;
    put(1, 0, 1'b1);
    put(1, 0, 1'b1);
    rst = 1'b0;
    put(1, 0, 1'b1);
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int bst(input int b);
    return int'(bank_state[3*b +: 3]);
  endfunction

  // Expected code for each variant with bank 0 in state s and bank 1 idle.
  function automatic int exp_code(input int s, input int v);
    if (v <= 1) return 0;
    if (v == 2) return (s == 6) ? 1 : 0;
    if (v <= 6) return (s == 1 || s == 2) ? 0 : 1;
    if (v == 7) return (s == 0) ? 0 : 1;
    if (v <= 9) return (s == 0 || s == 1 || s == 4) ? 0 : 1;
    return (s == 0) ? 0 : 1;
  endfunction

  task automatic reach(input int s);
    case (s)
      1: begin put(7, 0, 1'b1); nop(5); end
      2: begin put(7, 0, 1'b1); nop(5); put(5, 0, 1'b1); end
      3: begin put(7, 0, 1'b1); nop(5); put(6, 0, 1'b1); end
      4: begin put(7, 0, 1'b1); nop(5); put(8, 0, 1'b1); end
      5: put(10, 0, 1'b1);
      6: put(11, 0, 1'b1);
      default: ;
    endcase
  endtask

  initial begin
    rst = 1'b1; clk_en = 1'b1; cs_n = 1'b1; r_n = 1'b1; c_n = 1'b1; w_n = 1'b1;
    ap = 1'b0; bsel = 1'b0;
    reset_dut();

    // R13: reset state
    chk(bst(0) == 0 && bst(1) == 0, "R13 banks idle after reset", bst(0) + bst(1), 0);
    chk(illegal == 1'b0 && viol_code == 4'd0, "R13 flag clear after reset", int'(viol_code), 0);
    chk(pwr_state == 2'd0, "R13 running after reset", int'(pwr_state), 0);

    // R1 R7 R8 R9 R10: sweep every variant over every reachable bank state
    for (int s = 0; s < 7; s++) begin
      for (int v = 0; v < 12; v++) begin
        reset_dut();
        reach(s);
        chk(bst(0) == s, "R1 sweep state reached", bst(0), s);
        put(v, 0, 1'b1);
        chk(int'(viol_code) == exp_code(s, v), "R8 sweep verdict", int'(viol_code), exp_code(s, v));
        chk(illegal == (exp_code(s, v) != 0), "R2 sweep flag", int'(illegal), int'(exp_code(s, v) != 0));
      end
    end

    // R3: column command too early, then on time
    reset_dut();
    put(7, 0, 1'b1);
    chk(bst(0) == 1, "R3 activate gives row active", bst(0), 1);
    put(3, 0, 1'b1);
    chk(viol_code == 4'd2, "R3 read one edge after activate", int'(viol_code), 2);
    put(3, 0, 1'b1);
    chk(viol_code == 4'd0, "R3 read at TRCD", int'(viol_code), 0);

    // R4: precharge too early, then timed precharge
    reset_dut();
    put(7, 0, 1'b1); nop(2);
    put(8, 0, 1'b1);
    chk(viol_code == 4'd3, "R4 precharge before TRAS", int'(viol_code), 3);
    put(8, 0, 1'b1);
    chk(viol_code == 4'd0 && bst(0) == 4, "R4 precharge accepted", bst(0), 4);
    nop(1);
    chk(bst(0) == 4, "R4 precharging second cycle", bst(0), 4);
    nop(1);
    chk(bst(0) == 0, "R4 idle after TRP", bst(0), 0);

    // R4: precharge-all reaches both banks
    reset_dut();
    put(7, 0, 1'b1); nop(1); put(7, 1, 1'b1); nop(4);
    put(9, 0, 1'b1);
    chk(bst(0) == 4 && bst(1) == 4, "R4 precharge-all", bst(0) * 8 + bst(1), 36);

    // R5 R2: activate spacing, pulse length, state untouched
    reset_dut();
    put(7, 0, 1'b1);
    put(7, 1, 1'b1);
    chk(viol_code == 4'd4 && illegal, "R5 activate too close", int'(viol_code), 4);
    chk(bst(1) == 0, "R2 rejected activate leaves bank idle", bst(1), 0);
    put(1, 0, 1'b1);
    chk(!illegal && viol_code == 4'd0, "R2 flag lasts one cycle", int'(illegal), 0);
    put(7, 1, 1'b1);
    chk(viol_code == 4'd0 && bst(1) == 1, "R5 activate after TRRD", bst(1), 1);

    // R6: write recovery lengths
    reset_dut();
    put(7, 0, 1'b1); nop(4);
    put(5, 0, 1'b1);
    chk(bst(0) == 2, "R6 write recovery entered", bst(0), 2);
    nop(1);
    chk(bst(0) == 2, "R6 write recovery second cycle", bst(0), 2);
    nop(1);
    chk(bst(0) == 1, "R6 back to row active", bst(0), 1);
    put(6, 0, 1'b1);
    chk(bst(0) == 3, "R6 recovery with auto-precharge", bst(0), 3);
    nop(2);
    chk(bst(0) == 4, "R6 auto-precharge precharging", bst(0), 4);
    nop(2);
    chk(bst(0) == 0, "R6 auto-precharge ends idle", bst(0), 0);

    // R7: command on the last recovery cycle meets the timed exit
    reset_dut();
    put(7, 0, 1'b1); nop(4);
    put(5, 0, 1'b1); nop(1);
    put(7, 0, 1'b1);
    chk(viol_code == 4'd1, "R7 activate judged in recovery", int'(viol_code), 1);
    chk(bst(0) == 1, "R7 timed exit still taken", bst(0), 1);

    // R9: refresh length on both banks
    reset_dut();
    put(10, 0, 1'b1);
    chk(bst(0) == 5 && bst(1) == 5, "R9 both banks refreshing", bst(1), 5);
    nop(3);
    chk(bst(0) == 5, "R9 still refreshing at TRC-1", bst(0), 5);
    nop(1);
    chk(bst(0) == 0 && bst(1) == 0, "R9 idle after TRC", bst(0), 0);

    // R10: mode access lasts two cycles
    reset_dut();
    put(11, 0, 1'b1); nop(1);
    chk(bst(0) == 6, "R10 mode access second cycle", bst(0), 6);
    nop(1);
    chk(bst(0) == 0, "R10 idle after two cycles", bst(0), 0);

    // R11: verdict follows the selected bank
    reset_dut();
    put(7, 1, 1'b1); nop(3);
    put(3, 0, 1'b1);
    chk(viol_code == 4'd1, "R11 read to idle bank", int'(viol_code), 1);
    put(3, 1, 1'b1);
    chk(viol_code == 4'd0, "R11 read to active bank", int'(viol_code), 0);

    // R12: power-down, ignored commands, wake, self refresh
    reset_dut();
    put(1, 0, 1'b0);
    chk(pwr_state == 2'd1, "R12 power-down entered", int'(pwr_state), 1);
    put(7, 0, 1'b0);
    chk(!illegal && bst(0) == 0, "R12 activate ignored in power-down", bst(0), 0);
    put(3, 0, 1'b1);
    chk(pwr_state == 2'd0 && !illegal, "R12 wake, command unjudged", int'(pwr_state), 0);
    put(3, 0, 1'b1);
    chk(viol_code == 4'd1, "R12 judging resumes", int'(viol_code), 1);
    put(10, 0, 1'b0);
    chk(pwr_state == 2'd2 && bst(0) == 0, "R12 self refresh entered", int'(pwr_state), 2);
    put(1, 0, 1'b1);
    chk(pwr_state == 2'd0, "R12 self refresh left", int'(pwr_state), 0);

    // R13: reset in the middle of activity
    put(7, 0, 1'b1);
    reset_dut();
    chk(bst(0) == 0 && !illegal, "R13 reset clears active bank", bst(0), 0);

    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nchk++;
      nfail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

endmodule